// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter and Transfer Sequencer

This block serves four peripherals that each want bytes moved to or from memory. Each peripheral raises its own request line, and these lines may change at any time relative to the block clock. The block synchronises the requests and keeps only those from enabled channels. It then asks the host processor for the bus. Once the host acknowledges, the block chooses one channel and runs a single-byte memory cycle for it. The choice uses either a fixed ranking or a ranking that rotates after each transfer.

Every transfer cycle has three phases:
- **Address phase.** The upper address byte goes out on the shared data lines, together with a latch strobe. The lower byte goes out on its own lines.
- **Strobe phase.** The memory read or write strobe is asserted. A low ready input holds the block in this phase for extra wait cycles.
- **Close phase.** The block steps the channel's address up by one and its remaining count down by one. It flags terminal count on the last byte and flags a mark every 128 bytes, counted from the end of the block.

When a channel's count is exhausted, the block disables that channel. When no enabled request is left, the block releases the bus. Software loads each channel's start address and its count (number of bytes minus one) through simple write ports. It then writes the mode word, which holds the enables, the per-channel directions and the priority scheme.

Top module: `dma_sequencer`

## Requirements
- R1: After reset the mode word is cleared, so every channel is disabled. No request then raises `holdReq`, `chanAck` stays 0, and both memory strobes stay high.
- R2: Each request passes through a two-flop synchroniser. An enabled, requesting channel raises `holdReq` within four clock cycles.
- R3: No `chanAck` bit is asserted unless `holdAck` is high. At most one `chanAck` bit is high at a time.
- R4: With mode bit 8 clear (fixed priority), the lower-numbered pending channel wins: channel 0 first, channel 3 last.
- R5: With mode bit 8 set (rotating priority), the search for the next winner starts at the channel after the one last served. Two continuously pending channels therefore alternate.
- R6: In the address phase, `addrStb` is high, `dataOut` carries address bits 15:8 and `addrLow` carries bits 7:0 of the current channel.
- R7: Mode bits 7:4 give each channel's direction. A 1 pulses `memWrN` low (peripheral to memory) and a 0 pulses `memRdN` low. The two strobes are never low together.
- R8: The strobe phase lasts one cycle when `ready` is high. Each cycle in which `ready` is sampled low adds one more strobe cycle.
- R9: A count of N−1 gives exactly N transfers. `tc` is asserted only on the last one, and that channel's enable (mode bits 3:0) clears.
- R10: `mark` is asserted on each transfer where the remaining count, before it is decremented, is a multiple of 128.
- R11: `holdReq` falls when no enabled channel is requesting.
- R12: A channel's address increases by one after each of its transfers, carrying across the byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanReq | input | 4 | Asynchronous per-channel requests |
| addrWr | input | 1 | Write `wrData` into the selected channel's address register |
| countWr | input | 1 | Write `wrData[13:0]` into the selected channel's count register |
| selChan | input | 2 | Channel chosen by `addrWr`/`countWr` |
| wrData | input | 16 | Data for address or count writes |
| modeWr | input | 1 | Load the mode word |
| modeData | input | 9 | [3:0] enables, [7:4] directions, [8] rotate |
| holdReq | output | 1 | Bus request to the host |
| holdAck | input | 1 | Bus grant from the host |
| ready | input | 1 | High ends the strobe phase; low inserts a wait cycle |
| chanAck | output | 4 | One-hot acknowledge to the served peripheral |
| memRdN | output | 1 | Active-low memory read strobe |
| memWrN | output | 1 | Active-low memory write strobe |
| addrLow | output | 8 | Low address byte |
| dataOut | output | 8 | High address byte during the address phase, else 0 |
| addrStb | output | 1 | Strobe for an external latch to capture `dataOut` |
| tc | output | 1 | Terminal count, on the last transfer of a block |
| mark | output | 1 | Every-128-bytes marker |

## Verification
The assertions assume the host keeps `holdAck` high for as long as `holdReq` is high once it has granted the bus. They also assume software writes the mode word only while the channel being closed is not also being reprogrammed. The bench models the host as a responder that grants two cycles after `holdReq` rises and withdraws only after `holdReq` falls. It performs every configuration write while the bus is idle. Peripheral requests stay level until their block finishes. `ready` is driven from a per-transfer wait budget, so it is only ever low during a strobe phase.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int CH_N = 4;
  localparam int CH_W = $clog2(CH_N);

  typedef struct packed {
    logic            grant;      // a channel owns the cycle
    logic [CH_W-1:0] chan;       // owning channel
    logic            addrPhase;  // high byte on data lines
    logic            strobe;     // memory strobe phase
    logic            advance;    // close phase: step address/count
  } ctl_t;

  // Lowest offset from the start point wins; start is 0 in fixed mode.
  function automatic logic [CH_W-1:0] pickChan(input logic [CH_N-1:0] pend,
                                               input logic rot,
                                               input logic [CH_W-1:0] last);
    logic [CH_W-1:0] start;
    logic [CH_W-1:0] idx;
    logic [CH_W-1:0] res;
    start = rot ? last + 1'b1 : '0;
    res   = start;
    for (int i = CH_N - 1; i >= 0; i--) begin
      idx = start + CH_W'(i);
      if (pend[idx]) res = idx;
    end
    return res;
  endfunction
endpackage

// File: rtl/dma_sync.sv
module dma_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [CH_N-1:0] pending,
  input  logic            rotate,
  input  logic            holdAck,
  input  logic            ready,
  output logic            holdReq,
  output ctl_t            ctl
);
  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_ADDR, S_XFER, S_END} state_t;

  state_t          state;
  logic [CH_W-1:0] curChan;
  logic [CH_W-1:0] lastChan;
  logic [CH_W-1:0] winner;

  assign winner = pickChan(pending, rotate, lastChan);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      curChan  <= '0;
      lastChan <= CH_W'(CH_N - 1);
    end else begin
      unique case (state)
        S_IDLE: if (|pending) state <= S_HOLD;
        S_HOLD: begin
          if (pending == '0) state <= S_IDLE;
          else if (holdAck) begin
            curChan <= winner;
            state   <= S_ADDR;
          end
        end
        S_ADDR: state <= S_XFER;
        S_XFER: if (ready) state <= S_END;
        S_END: begin
          lastChan <= curChan;
          state    <= S_HOLD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    holdReq       = (state != S_IDLE);
    ctl.grant     = (state == S_ADDR) || (state == S_XFER) || (state == S_END);
    ctl.chan      = curChan;
    ctl.addrPhase = (state == S_ADDR);
    ctl.strobe    = (state == S_XFER);
    ctl.advance   = (state == S_END);
  end

  assert_ack_waits_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && !holdAck) |=> (state != S_ADDR));

  assert_fixed_ch0_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && holdAck && pending[0] && !rotate) |=> (curChan == '0));

  assert_wait_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_XFER && !ready) |=> (state == S_XFER));

  assert_release_bus_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && pending == '0) |=> !holdReq);
endmodule

// File: rtl/dma_dpath.sv
module dma_dpath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 14,
  parameter int MARK_W = 7,
  parameter int LO_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_t               ctl,
  input  logic               addrWr,
  input  logic               countWr,
  input  logic [CH_W-1:0]    selChan,
  input  logic [ADDR_W-1:0]  wrData,
  input  logic               modeWr,
  input  logic [2*CH_N:0]    modeData,
  output logic [CH_N-1:0]    enables,
  output logic               rotate,
  output logic [CH_N-1:0]    chanAck,
  output logic               memRdN,
  output logic               memWrN,
  output logic [LO_W-1:0]    addrLow,
  output logic [ADDR_W-LO_W-1:0] dataOut,
  output logic               addrStb,
  output logic               tc,
  output logic               mark
);
  logic [ADDR_W-1:0] addrQ [CH_N];
  logic [CNT_W-1:0]  cntQ  [CH_N];
  logic [CH_N-1:0]   enQ;
  logic [CH_N-1:0]   dirQ;
  logic              rotQ;

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  curCnt;
  logic              curDir;
  logic              curEn;
  logic              lastByte;

  generate
    for (genvar c = 0; c < CH_N; c++) begin : g_chan
      always_ff @(posedge clk) begin
        if (!rstN) begin
          addrQ[c] <= '0;
          cntQ[c]  <= '0;
        end else begin
          if (addrWr && selChan == CH_W'(c))
            addrQ[c] <= wrData;
          else if (ctl.advance && ctl.chan == CH_W'(c))
            addrQ[c] <= addrQ[c] + 1'b1;
          if (countWr && selChan == CH_W'(c))
            cntQ[c] <= wrData[CNT_W-1:0];
          else if (ctl.advance && ctl.chan == CH_W'(c))
            cntQ[c] <= cntQ[c] - 1'b1;
        end
      end
    end
  endgenerate

  assign curAddr  = addrQ[ctl.chan];
  assign curCnt   = cntQ[ctl.chan];
  assign curDir   = dirQ[ctl.chan];
  assign curEn    = enQ[ctl.chan];
  assign lastByte = (curCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= '0;
      dirQ <= '0;
      rotQ <= 1'b0;
    end else if (modeWr) begin
      enQ  <= modeData[CH_N-1:0];
      dirQ <= modeData[2*CH_N-1:CH_N];
      rotQ <= modeData[2*CH_N];
    end else if (ctl.advance && lastByte) begin
      enQ[ctl.chan] <= 1'b0;
    end
  end

  always_comb begin
    enables = enQ;
    rotate  = rotQ;
    chanAck = '0;
    if (ctl.grant) chanAck[ctl.chan] = 1'b1;
    memWrN  = !(ctl.strobe && curDir);
    memRdN  = !(ctl.strobe && !curDir);
    addrStb = ctl.addrPhase;
    addrLow = ctl.grant ? curAddr[LO_W-1:0] : '0;
    dataOut = ctl.addrPhase ? curAddr[ADDR_W-1:LO_W] : '0;
    tc      = ctl.advance && lastByte;
    mark    = ctl.advance && (curCnt[MARK_W-1:0] == '0);
  end

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(!memRdN && !memWrN));

  assert_onehot_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanAck));

  assert_addr_step_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !addrWr) |=> (curAddr == $past(curAddr) + 1'b1));

  assert_tc_disables_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && lastByte && !modeWr) |=> !curEn);
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 14,
  parameter int MARK_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        chanReq,
  input  logic              addrWr,
  input  logic              countWr,
  input  logic [1:0]        selChan,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              modeWr,
  input  logic [8:0]        modeData,
  output logic              holdReq,
  input  logic              holdAck,
  input  logic              ready,
  output logic [3:0]        chanAck,
  output logic              memRdN,
  output logic              memWrN,
  output logic [7:0]        addrLow,
  output logic [ADDR_W-9:0] dataOut,
  output logic              addrStb,
  output logic              tc,
  output logic              mark
);
  logic [CH_N-1:0] reqSync;
  logic [CH_N-1:0] enables;
  logic [CH_N-1:0] pending;
  logic            rotate;
  ctl_t            ctl;

  dma_sync #(.WIDTH(CH_N), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(chanReq), .syncOut(reqSync)
  );

  assign pending = reqSync & enables;

  dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pending(pending), .rotate(rotate),
    .holdAck(holdAck), .ready(ready), .holdReq(holdReq), .ctl(ctl)
  );

  dma_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MARK_W(MARK_W), .LO_W(8)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .addrWr(addrWr), .countWr(countWr), .selChan(selChan), .wrData(wrData),
    .modeWr(modeWr), .modeData(modeData),
    .enables(enables), .rotate(rotate), .chanAck(chanAck),
    .memRdN(memRdN), .memWrN(memWrN), .addrLow(addrLow), .dataOut(dataOut),
    .addrStb(addrStb), .tc(tc), .mark(mark)
  );
endmodule

// File: tb/dma_sequencer_tb.sv
module dma_sequencer_tb;
  localparam int LOGN = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  chanReq = '0;
  logic        addrWr = 1'b0, countWr = 1'b0, modeWr = 1'b0;
  logic [1:0]  selChan = '0;
  logic [15:0] wrData = '0;
  logic [8:0]  modeData = '0;
  logic        holdReq, holdAck = 1'b0, ready = 1'b1;
  logic [3:0]  chanAck;
  logic        memRdN, memWrN, addrStb, tc, mark;
  logic [7:0]  addrLow, dataOut;

  dma_sequencer u_dut (
    .clk(clk), .rstN(rstN), .chanReq(chanReq), .addrWr(addrWr), .countWr(countWr),
    .selChan(selChan), .wrData(wrData), .modeWr(modeWr), .modeData(modeData),
    .holdReq(holdReq), .holdAck(holdAck), .ready(ready), .chanAck(chanAck),
    .memRdN(memRdN), .memWrN(memWrN), .addrLow(addrLow), .dataOut(dataOut),
    .addrStb(addrStb), .tc(tc), .mark(mark)
  );

  always #4 clk = ~clk;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  int        logN = 0;
  int        logCh   [LOGN];
  bit [15:0] logAddr [LOGN];
  bit        logTc   [LOGN];
  bit        logMark [LOGN];
  int        logStrb [LOGN];
  bit        logWr   [LOGN];
  int        ackViol = 0;
  int        waitPer = 0, waitLeft = 0, holdCnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Host model, ready model and transfer logger, all at the falling edge.
  always @(negedge clk) begin
    if (holdReq) begin holdCnt++; holdAck = (holdCnt >= 2); end
    else begin holdCnt = 0; holdAck = 1'b0; end
    if ((chanAck != 4'b0 && !holdAck) || $countones(chanAck) > 1) ackViol++;
    if (addrStb && logN < LOGN) begin
      logCh[logN] = 0;
      for (int i = 0; i < 4; i++) if (chanAck[i]) logCh[logN] = i;
      logAddr[logN] = {dataOut, addrLow};
      logTc[logN] = 0; logMark[logN] = 0; logStrb[logN] = 0; logWr[logN] = 0;
      logN++;
      waitLeft = waitPer;
    end
    if (!memRdN || !memWrN) begin
      if (logN > 0) begin logStrb[logN-1]++; logWr[logN-1] = !memWrN; end
      ready = !(waitLeft > 0);
      if (waitLeft > 0) waitLeft--;
    end else ready = 1'b1;
    if (logN > 0 && tc)   logTc[logN-1] = 1;
    if (logN > 0 && mark) logMark[logN-1] = 1;
  end

  task automatic clearLog();
    logN = 0; ackViol = 0;
  endtask

  task automatic wrAddr(input int ch, input int val);
    @(negedge clk); selChan = 2'(ch); wrData = 16'(val); addrWr = 1;
    @(negedge clk); addrWr = 0;
  endtask

  task automatic wrCount(input int ch, input int val);
    @(negedge clk); selChan = 2'(ch); wrData = 16'(val); countWr = 1;
    @(negedge clk); countWr = 0;
  endtask

  task automatic wrMode(input int val);
    @(negedge clk); modeData = 9'(val); modeWr = 1;
    @(negedge clk); modeWr = 0;
  endtask

  task automatic runUntilFree(input logic [3:0] reqs);
    @(negedge clk); chanReq = reqs;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 5000; i++) begin
      if (!holdReq) break;
      @(negedge clk);
    end
    chanReq = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!holdReq, "R1 holdReq after reset", holdReq, 0);
    chk(chanAck == 0, "R1 chanAck after reset", chanAck, 0);
    chk(memRdN && memWrN, "R1 strobes idle", {memRdN, memWrN}, 3);
    chanReq = 4'hF;
    repeat (10) @(negedge clk);
    chk(!holdReq, "R1 requests ignored while disabled", holdReq, 0);
    chanReq = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testSingle();
    clearLog(); waitPer = 0;
    wrAddr(2, 16'h12FE); wrCount(2, 2); wrMode(9'h040 | 9'h004);
    @(negedge clk); chanReq = 4'b0100;
    repeat (4) @(negedge clk);
    chk(holdReq, "R2 holdReq raised after sync", holdReq, 1);
    runUntilFree(4'b0100);
    chk(logN == 3, "R9 transfer count N", logN, 3);
    chk(logAddr[0] == 16'h12FE, "R6 first address", logAddr[0], 16'h12FE);
    chk(logAddr[2] == 16'h1300, "R12 carry into high byte", logAddr[2], 16'h1300);
    chk(logTc[2] && !logTc[0] && !logTc[1], "R9 tc only on last", {logTc[0], logTc[1], logTc[2]}, 1);
    chk(logWr[0] && logCh[0] == 2, "R7 write strobe on ch2", logWr[0], 1);
    chk(logStrb[1] == 1, "R8 no wait when ready", logStrb[1], 1);
    chk(ackViol == 0, "R3 ack only under hold", ackViol, 0);
    chk(!holdReq, "R11 bus released", holdReq, 0);
    runUntilFree(4'b0100);
    chk(logN == 3, "R9 channel disabled after tc", logN, 3);
  endtask

  task automatic testFixed();
    clearLog();
    wrAddr(1, 16'h0100); wrCount(1, 1);
    wrAddr(3, 16'h0300); wrCount(3, 1);
    wrMode(9'h00A);
    runUntilFree(4'b1010);
    chk(logN == 4, "R4 four transfers", logN, 4);
    chk(logCh[0] == 1 && logCh[1] == 1 && logCh[2] == 3 && logCh[3] == 3,
        "R4 fixed order 1,1,3,3", logCh[0]*1000 + logCh[1]*100 + logCh[2]*10 + logCh[3], 1133);
    chk(!logWr[0] && logStrb[0] == 1, "R7 read strobe", logWr[0], 0);
    chk(logAddr[3] == 16'h0301, "R12 ch3 step", logAddr[3], 16'h0301);
  endtask

  task automatic testRotate();
    clearLog();
    wrAddr(0, 16'h0A00); wrCount(0, 1);
    wrAddr(2, 16'h0B00); wrCount(2, 1);
    wrMode(9'h105);
    runUntilFree(4'b0101);
    chk(logN == 4, "R5 four transfers", logN, 4);
    chk(logCh[0] == 0 && logCh[1] == 2 && logCh[2] == 0 && logCh[3] == 2,
        "R5 rotating order 0,2,0,2", logCh[0]*1000 + logCh[1]*100 + logCh[2]*10 + logCh[3], 202);
  endtask

  task automatic testWait();
    clearLog(); waitPer = 3;
    wrAddr(0, 16'h2000); wrCount(0, 0); wrMode(9'h001);
    runUntilFree(4'b0001);
    waitPer = 0;
    chk(logN == 1, "R8 single transfer", logN, 1);
    chk(logStrb[0] == 4, "R8 three wait cycles", logStrb[0], 4);
    chk(logTc[0], "R9 tc with count 0", logTc[0], 1);
  endtask

  task automatic testMark();
    int nMark;
    clearLog();
    wrAddr(1, 16'h0000); wrCount(1, 255); wrMode(9'h002);
    runUntilFree(4'b0010);
    nMark = 0;
    for (int i = 0; i < logN; i++) nMark += logMark[i];
    chk(logN == 256, "R9 256 transfers", logN, 256);
    chk(nMark == 2, "R10 mark count", nMark, 2);
    chk(logMark[127] && logMark[255], "R10 mark positions", {logMark[127], logMark[255]}, 3);
    chk(logAddr[255] == 16'h00FF, "R12 final address", logAddr[255], 16'h00FF);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSingle();
    testFixed();
    testRotate();
    testWait();
    testMark();
    finish();
  end
endmodule